// File: doc/BRIEF.md
# Protected Clock Prescaler

The block divides the master clock by a power of two and emits a one-cycle clock enable that downstream synchronous logic uses as its tick. A 4-bit select code picks the factor: code N gives a factor of 2^N, for N from 0 to 8. Codes above 8 are never taken. The factor leaves reset at 8.

A small register bus reaches two byte-wide registers. One is a guard register and the other holds the select code. A new select code is accepted only inside a short unlock window. A write of the signature value to the guard register opens that window. The window lapses after four master-clock cycles, and it also closes on any accepted or refused attempt to write the select code.

The bus is a plain control path with no back-pressure. A write is taken in the cycle in which `bus_we_i` is high. Reads are combinational on `bus_addr_i`. A newly accepted factor does not reach the divider at once. It waits for a cycle in which the free-running counter lies on a period boundary of both the old factor and the new one, so no enable interval is ever cut short or stretched.

Top module: `ckp_prescaler`

## Requirements
- R1: A read at the select address (address 1) returns the select code in bits 3:0 and zero in bits 7:4. Bits 7:4 of any write data at that address are ignored.
- R2: A read at the guard address (address 0) returns 8'h00. A read at any other unused address (2 or 3) also returns 8'h00.
- R3: After reset the select code reads 3, the enable repeats every 8 cycles starting from the first cycle after reset, and no unlock window is open.
- R4: A write to the select address while no window is open leaves the code unchanged. A guard write with any value other than the signature (default 8'hD8) closes any open window.
- R5: A signature write opens a window in which a select write is accepted during the 1st to 4th cycle after it. A select write in the 5th cycle or later is refused. Any select write made inside the window closes the window, so a second write right after it is refused.
- R6: A select write of code 9 to 15 inside the window is refused. The old code is kept and the window closes.
- R7: An 8-bit counter starts at 0 after reset and steps once per cycle. `clk_en_o` is high in exactly the cycles where the low N bits of the counter are zero, with N the code in use. Code 0 gives an enable on every cycle.
- R8: An accepted code goes into use at the clock edge after a cycle in which the counter's low max(old,new) bits are all zero. Until then the old factor stays in use.
- R9: After the first enable, the distance in cycles between two enables always equals the factor in use over that interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address: 0 guard, 1 select, 2 and 3 unused |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| clk_en_o | output | 1 | One-cycle enable at each divided period boundary |

## Verification
A window counter stuck open or one that closes early changes the outcome of the first select write that follows. A read-back of the select code shows this on the very next cycle. A wrong select code or a code applied too soon shows up at `clk_en_o` within one divided period, at most 256 cycles, as an enable out of place or a gap of the wrong length. A counter that slips or skips shows up as an enable at the wrong cycle at the next boundary. A cycle-accurate bench model checks every cycle, so each of these faults appears as a mismatch on the first differing cycle.

// File: rtl/ckp_pkg.sv
package ckp_pkg;

  // Low-bit mask for a power-of-two factor 2**code, as 32 bits.
  function automatic logic [31:0] ckp_mask(input logic [3:0] code);
    return (32'd1 << code) - 32'd1;
  endfunction

  // Larger of two select codes.
  function automatic logic [3:0] ckp_max(input logic [3:0] a, input logic [3:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ckp_unlock.sv
module ckp_unlock #(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  SIGNATURE = 8'hD8,
  parameter int          WINDOW    = 4,
  localparam int         WIN_W     = $clog2(WINDOW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              guard_wr_i,
  input  logic              sel_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);

  logic [WIN_W-1:0] left_q;
  logic [WIN_W-1:0] left_d;

  assign open_o = (left_q != '0);

  always_comb begin
    left_d = left_q;
    if (guard_wr_i) begin
      left_d = (wdata_i == DATA_W'(SIGNATURE)) ? WIN_W'(WINDOW) : '0;
    end else if (sel_wr_i && open_o) begin
      left_d = '0;
    end else if (open_o) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else         left_q <= left_d;
  end

endmodule

// File: rtl/ckp_select_reg.sv
module ckp_select_reg #(
  parameter int SEL_W      = 4,
  parameter int MAX_CODE   = 8,
  parameter int RESET_CODE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_wr_i,
  input  logic             open_i,
  input  logic [SEL_W-1:0] code_i,
  output logic [SEL_W-1:0] sel_o
);

  logic legal;
  logic take;

  assign legal = (code_i <= SEL_W'(MAX_CODE));
  assign take  = sel_wr_i && open_i && legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= SEL_W'(RESET_CODE);
    else if (take) sel_o <= code_i;
  end

endmodule

// File: rtl/ckp_divider.sv
module ckp_divider #(
  parameter int SEL_W      = 4,
  parameter int CNT_W      = 8,
  parameter int RESET_CODE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] act_o,
  output logic             en_o
);
  import ckp_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_mask;
  logic [CNT_W-1:0] join_mask;
  logic             swap;

  assign act_mask  = CNT_W'(ckp_mask(4'(act_o)));
  assign join_mask = CNT_W'(ckp_mask(ckp_max(4'(act_o), 4'(sel_i))));
  assign en_o      = ((cnt_q & act_mask) == '0);
  assign swap      = (sel_i != act_o) && ((cnt_q & join_mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_o <= SEL_W'(RESET_CODE);
    else if (swap) act_o <= sel_i;
  end

endmodule

// File: rtl/ckp_prescaler.sv
module ckp_prescaler #(
  parameter int         ADDR_W     = 2,
  parameter int         DATA_W     = 8,
  parameter int         SEL_W      = 4,
  parameter int         MAX_CODE   = 8,
  parameter int         RESET_CODE = 3,
  parameter int         WINDOW     = 4,
  parameter logic [7:0] SIGNATURE  = 8'hD8,
  parameter int         GUARD_ADDR = 0,
  parameter int         SEL_ADDR   = 1,
  localparam int        CNT_W      = MAX_CODE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              clk_en_o
);

  logic             guard_wr;
  logic             sel_wr;
  logic             win_open;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] act_q;

  assign guard_wr = bus_we_i && (bus_addr_i == ADDR_W'(GUARD_ADDR));
  assign sel_wr   = bus_we_i && (bus_addr_i == ADDR_W'(SEL_ADDR));

  ckp_unlock #(
    .DATA_W(DATA_W), .SIGNATURE(SIGNATURE), .WINDOW(WINDOW)
  ) u_unlock (
    .clk_i(clk_i), .rst_ni(rst_ni), .guard_wr_i(guard_wr),
    .sel_wr_i(sel_wr), .wdata_i(bus_wdata_i), .open_o(win_open)
  );

  ckp_select_reg #(
    .SEL_W(SEL_W), .MAX_CODE(MAX_CODE), .RESET_CODE(RESET_CODE)
  ) u_select (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_wr_i(sel_wr), .open_i(win_open),
    .code_i(bus_wdata_i[SEL_W-1:0]), .sel_o(sel_q)
  );

  ckp_divider #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .RESET_CODE(RESET_CODE)
  ) u_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_q), .act_o(act_q), .en_o(clk_en_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(SEL_ADDR)) begin
      bus_rdata_o = {{(DATA_W-SEL_W){1'b0}}, sel_q};
    end
  end

endmodule

// File: rtl/ckp_prescaler_chk.sv
module ckp_prescaler_chk #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 4,
  parameter int MAX_CODE   = 8,
  parameter int GUARD_ADDR = 0,
  parameter int SEL_ADDR   = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              clk_en_o,
  input logic              win_open,
  input logic              sel_wr,
  input logic [SEL_W-1:0]  sel_q,
  input logic [SEL_W-1:0]  act_q
);

  logic [9:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (clk_en_o) begin
      gap_q  <= 10'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 10'h3FF) begin
      gap_q  <= gap_q + 10'd1;
    end
  end

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:SEL_W] == '0); // R1
  AST_GUARD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(GUARD_ADDR)) |-> (bus_rdata_o == '0)); // R2
  AST_LOCKED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_open && sel_wr) |=> $stable(sel_q)); // R4
  AST_WINDOW_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && sel_wr) |=> !win_open); // R5
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q <= SEL_W'(MAX_CODE)); // R6
  AST_UNITY_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == '0) |-> clk_en_o); // R7
  AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |=> $stable(act_q)); // R8
  AST_PULSE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && seen_q) |-> (gap_q == (10'd1 << act_q))); // R9

endmodule

bind ckp_prescaler ckp_prescaler_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .MAX_CODE(MAX_CODE),
  .GUARD_ADDR(GUARD_ADDR), .SEL_ADDR(SEL_ADDR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .clk_en_o(clk_en_o), .win_open(win_open),
  .sel_wr(sel_wr), .sel_q(sel_q), .act_q(act_q)
);

// File: tb/ckp_prescaler_tb_top.sv
`timescale 1ns/1ps
module ckp_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ckp_prescaler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .clk_en_o(en)
  );

  // Reference state taken from the requirements
  logic [7:0] m_cnt;
  logic [3:0] m_sel, m_act;
  int         m_win;
  int         gap;
  bit         seen;

  function automatic logic [7:0] f_mask(input logic [3:0] c);
    return 8'(((32'd1 << c) - 32'd1));
  endfunction

  function automatic logic f_en(input logic [7:0] c, input logic [3:0] a);
    return (c & f_mask(a)) == 8'd0;
  endfunction

  function automatic logic [7:0] f_read(input logic [1:0] a, input logic [3:0] s);
    return (a == 2'd1) ? {4'd0, s} : 8'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 8'd0; m_sel <= 4'd3; m_act <= 4'd3; m_win <= 0;
    end else begin
      m_cnt <= m_cnt + 8'd1;
      if (m_sel != m_act && (m_cnt & f_mask((m_sel > m_act) ? m_sel : m_act)) == 8'd0)
        m_act <= m_sel;
      if (we && addr == 2'd0)       m_win <= (wdata == 8'hD8) ? 4 : 0;
      else if (we && addr == 2'd1 && m_win > 0) begin
        m_win <= 0;
        if (wdata[3:0] <= 4'd8) m_sel <= wdata[3:0];
      end else if (m_win > 0)       m_win <= m_win - 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(en == f_en(m_cnt, m_act), "R7 R8 enable", en, f_en(m_cnt, m_act));
      check(rdata == f_read(addr, m_sel), "R1 R2 readback", rdata, f_read(addr, m_sel));
      if (en) begin
        if (seen) check(gap == (1 << m_act), "R9 spacing", gap, 1 << m_act);
        seen = 1'b1;
        gap = 1;
      end else begin
        gap++;
      end
    end
  end

  task automatic cyc(input logic [1:0] a, input logic w, input logic [7:0] d);
    @(posedge clk); #2;
    addr = a; we = w; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(2'd2, 1'b0, 8'h00);
  endtask

  task automatic expect_sel(input logic [7:0] exp, input string req);
    cyc(2'd1, 1'b0, 8'h00);
    @(negedge clk); #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R3: reset value and first enable
    @(negedge clk); #1;
    check(en == 1'b1, "R3 first enable", en, 1);
    expect_sel(8'h03, "R3 reset code");
    cyc(2'd0, 1'b0, 8'h00);
    @(negedge clk); #1;
    check(rdata == 8'h00, "R2 guard read", rdata, 0);
    cyc(2'd3, 1'b0, 8'h00);
    @(negedge clk); #1;
    check(rdata == 8'h00, "R2 unused read", rdata, 0);
    // R4: locked write
    cyc(2'd1, 1'b1, 8'h05);
    expect_sel(8'h03, "R4 locked write");
    // R1 + R5: immediate write with upper bits set
    cyc(2'd0, 1'b1, 8'hD8); cyc(2'd1, 1'b1, 8'hF2);
    expect_sel(8'h02, "R1 upper bits ignored");
    // R5: 4th cycle accepted
    cyc(2'd0, 1'b1, 8'hD8); idle(3); cyc(2'd1, 1'b1, 8'h04);
    expect_sel(8'h04, "R5 fourth cycle");
    // R5: 5th cycle refused
    cyc(2'd0, 1'b1, 8'hD8); idle(4); cyc(2'd1, 1'b1, 8'h01);
    expect_sel(8'h04, "R5 window lapsed");
    // R5: second write refused
    cyc(2'd0, 1'b1, 8'hD8); cyc(2'd1, 1'b1, 8'h06); cyc(2'd1, 1'b1, 8'h07);
    expect_sel(8'h06, "R5 window closed");
    // R4: wrong guard value closes window
    cyc(2'd0, 1'b1, 8'hD8); cyc(2'd0, 1'b1, 8'h55); cyc(2'd1, 1'b1, 8'h01);
    expect_sel(8'h06, "R4 bad signature");
    // R6: reserved code refused, window closes
    cyc(2'd0, 1'b1, 8'hD8); cyc(2'd1, 1'b1, 8'h0B); cyc(2'd1, 1'b1, 8'h01);
    expect_sel(8'h06, "R6 reserved code");
    // R8: largest factor then back to unity
    cyc(2'd0, 1'b1, 8'hD8); cyc(2'd1, 1'b1, 8'h08);
    expect_sel(8'h08, "R8 max factor");
    idle(600);
    cyc(2'd0, 1'b1, 8'hD8); cyc(2'd1, 1'b1, 8'h00);
    expect_sel(8'h00, "R8 unity factor");
    idle(300);
    // Random phase with a fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = ($urandom_range(0, 2) == 0) ? 8'hD8 : 8'($urandom_range(0, 255));
      if (a == 2'd1) d = {4'($urandom), 4'($urandom_range(0, 10))};
      cyc(a, ($urandom_range(0, 3) != 0), d);
      if ($urandom_range(0, 9) == 0) idle(int'($urandom_range(1, 40)));
    end
    idle(10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule